// File: doc/BRIEF.md
# SCL-Low Time-out Watchdog

This block guards a two-wire serial bus controller against a clock line that stays LOW for too long. It watches an already synchronized copy of SCL and counts how long each LOW spell lasts, in units of a slow tick. The tick comes from a built-in parameterized clock divider. A configuration byte supplies the limit. Its top bit turns the guard on, and its lower seven bits give a count N. The limit is then N+1 ticks.

Timing applies only while the controller owns the bus or is waiting to issue a START. The master-active and START-pending inputs report those two conditions. Every SCL transition restarts the count from N. When a LOW spell reaches the limit, the block latches a bus error and does three things:
- it sends a one-cycle request to load status code 0x90;
- it raises the interrupt request;
- it tells the SCL and SDA drivers to let go of the bus.

The error stays latched until the synchronous reset is applied. Nothing else clears it. The byte-level protocol engine sits outside this block and consumes these outputs.

Top module: `scl_lowtime_watchdog`

## Requirements
- R1: After reset, `bus_err`, `irq_req`, `release_bus` and `status_load` are all 0.
- R2: With bit 7 of `cfg_word` set and the block operating, SCL is sampled LOW at some clock edge k, counting the edge where the fall is first seen. If SCL then stays LOW, `bus_err` reads 1 after edge k+(N+1)*TICK_CYCLES and 0 before it, where N = `cfg_word[6:0]`.
- R3: While bit 7 of `cfg_word` is 0, no error is raised, whatever the length of the LOW spell.
- R4: Every SCL transition reloads the count from N, so a LOW spell shorter than the limit that is followed by an edge never raises an error, and the next spell is timed in full.
- R5: While SCL is HIGH, no time is accumulated and no error is raised.
- R6: The block operates only while `master_active` or `start_pending` is 1. With both at 0, no error is raised.
- R7: With `start_pending` at 1 and `master_active` at 0, a LOW spell is timed to the same limit as in R2.
- R8: On expiry, `status_load` is 1 for exactly one cycle, in the cycle `bus_err` first reads 1. `status_code` is 0x90, and `irq_req` and `release_bus` are 1.
- R9: Once set, `bus_err`, `irq_req` and `release_bus` stay 1 regardless of `cfg_word`, SCL or the mode inputs. Only `rst` clears them.
- R10: With N = 0, the limit is exactly one tick (TICK_CYCLES clock cycles).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; the only way to clear a latched error |
| cfg_word | input | 8 | Bit 7 is the time-out enable; bits 6:0 hold the count N |
| scl_in | input | 1 | Synchronized SCL level |
| master_active | input | 1 | Controller is acting as bus master |
| start_pending | input | 1 | Controller is waiting to send a START |
| status_load | output | 1 | One-cycle request to load `status_code` into the status register |
| status_code | output | 8 | Bus-error status code, 0x90 |
| irq_req | output | 1 | Interrupt request, held while the error is latched |
| release_bus | output | 1 | Command to release SCL and SDA, held while the error is latched |
| bus_err | output | 1 | Latched bus-error flag |

## Verification
The main function is checked with LOW spells of different counts (mid-range, zero, and a START-pending-only case). Each check samples the exact edge before and after expiry, which separates an off-by-one in the tick or count path from a correct limit.

Some spells are cut short by a HIGH pulse and then restarted, which shows that edges reload the count rather than pause it. Long LOW spells with the enable bit off, or with neither mode input active, show that timing is gated. Finally, the inputs are changed after an error to show that only reset clears the latch.

// File: rtl/sclto_pkg.sv
package sclto_pkg;

    // Width of the count field inside the configuration byte.
    localparam int unsigned CNT_W = 7;
    localparam int unsigned CFG_W = CNT_W + 1;

    // Status code requested on a bus error.
    localparam logic [7:0] BUS_ERR_CODE = 8'h90;

    typedef struct packed {
        logic             enable;
        logic [CNT_W-1:0] count;
    } to_cfg_t;

    function automatic to_cfg_t unpack_cfg(input logic [CFG_W-1:0] word);
        to_cfg_t c;
        c.enable = word[CFG_W-1];
        c.count  = word[CNT_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/sclto_tick_gen.sv
module sclto_tick_gen #(
    parameter int unsigned TICK_CYCLES = 1137
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    output logic tick_o
);
    localparam int unsigned PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

    generate
        if (TICK_CYCLES <= 1) begin : g_every_cycle
            assign tick_o = !clear_i;
        end else begin : g_divider
            logic [PRE_W-1:0] pre_q;
            logic             wrap;

            assign wrap   = (pre_q == PRE_W'(TICK_CYCLES - 1));
            assign tick_o = wrap && !clear_i;

            always_ff @(posedge clk) begin
                if (rst || clear_i || wrap) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end

            // R2: a tick is never followed by another tick on the next cycle
            p_tick_spaced_r2: assert property (@(posedge clk) disable iff (rst)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/sclto_scl_mon.sv
module sclto_scl_mon (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    output logic scl_low_o,
    output logic scl_edge_o
);
    logic scl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
        end
    end

    assign scl_low_o  = !scl_i;
    assign scl_edge_o = (scl_i != scl_q);

endmodule

// File: rtl/sclto_timer.sv
module sclto_timer
    import sclto_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  to_cfg_t          cfg_i,
    input  logic             operating_i,
    input  logic             scl_low_i,
    input  logic             scl_edge_i,
    input  logic             tick_i,
    output logic             hold_o,
    output logic             err_o,
    output logic             load_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             err_q;
    logic             load_q;
    logic             armed;
    logic             expire;

    assign armed  = cfg_i.enable && operating_i && scl_low_i;
    assign hold_o = !armed || scl_edge_i || err_q;
    assign expire = !hold_o && tick_i && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= cfg_i.count;
            err_q  <= 1'b0;
            load_q <= 1'b0;
        end else begin
            load_q <= expire;
            if (expire) begin
                err_q <= 1'b1;
            end
            if (hold_o) begin
                cnt_q <= cfg_i.count;
            end else if (tick_i && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign err_o  = err_q;
    assign load_o = load_q;

    // R9: the error latch never drops without reset
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

    // R3: an error only appears after a cycle that was enabled, operating and LOW
    p_err_needs_arm_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q) |-> $past(cfg_i.enable && operating_i && scl_low_i));

    // R8: the status load request lasts a single cycle
    p_load_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        load_q |=> !load_q);

endmodule

// File: rtl/scl_lowtime_watchdog.sv
module scl_lowtime_watchdog
    import sclto_pkg::*;
#(
    parameter int unsigned TICK_CYCLES = 1137
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             scl_in,
    input  logic             master_active,
    input  logic             start_pending,
    output logic             status_load,
    output logic [7:0]       status_code,
    output logic             irq_req,
    output logic             release_bus,
    output logic             bus_err
);
    to_cfg_t cfg;
    logic    scl_low;
    logic    scl_edge;
    logic    tick;
    logic    hold;
    logic    err;

    assign cfg = unpack_cfg(cfg_word);

    sclto_scl_mon u_mon (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_in),
        .scl_low_o  (scl_low),
        .scl_edge_o (scl_edge)
    );

    sclto_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .clear_i (hold),
        .tick_o  (tick)
    );

    sclto_timer u_timer (
        .clk         (clk),
        .rst         (rst),
        .cfg_i       (cfg),
        .operating_i (master_active || start_pending),
        .scl_low_i   (scl_low),
        .scl_edge_i  (scl_edge),
        .tick_i      (tick),
        .hold_o      (hold),
        .err_o       (err),
        .load_o      (status_load)
    );

    assign status_code = BUS_ERR_CODE;
    assign bus_err     = err;
    assign irq_req     = err;
    assign release_bus = err;

    // R8: a status load request is only issued together with a latched error
    p_load_with_err_r8: assert property (@(posedge clk) disable iff (rst)
        status_load |-> (irq_req && release_bus));

endmodule

// File: tb/scl_lowtime_watchdog_tb.sv
module scl_lowtime_watchdog_tb_top;
    localparam int unsigned TICK = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cfg_word = 8'h00;
    logic       scl_in = 1'b1;
    logic       master_active = 1'b0;
    logic       start_pending = 1'b0;
    logic       status_load;
    logic [7:0] status_code;
    logic       irq_req;
    logic       release_bus;
    logic       bus_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    scl_lowtime_watchdog #(.TICK_CYCLES(TICK)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .cfg_word      (cfg_word),
        .scl_in        (scl_in),
        .master_active (master_active),
        .start_pending (start_pending),
        .status_load   (status_load),
        .status_code   (status_code),
        .irq_req       (irq_req),
        .release_bus   (release_bus),
        .bus_err       (bus_err)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; scl_in = 1'b1; master_active = 1'b0; start_pending = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Drive SCL low at a negedge and check the exact expiry edge.
    task automatic timed_low(input logic [7:0] cfg, input string tag);
        int e;
        e = (int'(cfg[6:0]) + 1) * TICK;
        cfg_word = cfg;
        @(negedge clk);
        scl_in = 1'b0;
        edges(e);
        chk({7'd0, bus_err}, 8'd0, {tag, " before expiry"});
        edges(1);
        chk({7'd0, bus_err}, 8'd1, {tag, " at expiry"});
        chk({7'd0, status_load}, 8'd1, {tag, " R8 load pulse"});
        chk(status_code, 8'h90, {tag, " R8 code"});
        chk({6'd0, irq_req, release_bus}, 8'd3, {tag, " R8 irq/release"});
        edges(1);
        chk({7'd0, status_load}, 8'd0, {tag, " R8 load single cycle"});
    endtask

    task automatic test_reset_r1();
        do_reset();
        chk({4'd0, bus_err, irq_req, release_bus, status_load}, 8'd0, "R1 reset outputs");
    endtask

    task automatic test_period_r2();
        do_reset();
        master_active = 1'b1;
        timed_low(8'h83, "R2 N=3");
        do_reset();
        master_active = 1'b1;
        timed_low(8'h8A, "R2 N=10");
    endtask

    task automatic test_disabled_r3();
        do_reset();
        master_active = 1'b1;
        cfg_word = 8'h05;
        @(negedge clk); scl_in = 1'b0;
        edges(300);
        chk({6'd0, bus_err, irq_req}, 8'd0, "R3 enable off");
    endtask

    task automatic test_reload_r4();
        do_reset();
        master_active = 1'b1;
        cfg_word = 8'h83;
        @(negedge clk); scl_in = 1'b0;
        edges(14);
        scl_in = 1'b1;
        edges(1);
        chk({7'd0, bus_err}, 8'd0, "R4 short spell");
        timed_low(8'h83, "R4 restart");
    endtask

    task automatic test_high_r5();
        do_reset();
        master_active = 1'b1;
        cfg_word = 8'h80;
        edges(200);
        chk({7'd0, bus_err}, 8'd0, "R5 scl high");
    endtask

    task automatic test_idle_r6();
        do_reset();
        cfg_word = 8'h81;
        @(negedge clk); scl_in = 1'b0;
        edges(200);
        chk({7'd0, bus_err}, 8'd0, "R6 not operating");
    endtask

    task automatic test_start_r7();
        do_reset();
        start_pending = 1'b1;
        timed_low(8'h82, "R7 start pending");
    endtask

    task automatic test_sticky_r9();
        do_reset();
        master_active = 1'b1;
        timed_low(8'h81, "R9 setup");
        cfg_word = 8'h00; scl_in = 1'b1; master_active = 1'b0;
        edges(20);
        chk({5'd0, bus_err, irq_req, release_bus}, 8'd7, "R9 held");
        rst = 1'b1;
        edges(1);
        rst = 1'b0;
        edges(1);
        chk({5'd0, bus_err, irq_req, release_bus}, 8'd0, "R9 cleared by reset");
    endtask

    task automatic test_zero_r10();
        do_reset();
        master_active = 1'b1;
        timed_low(8'h80, "R10 N=0");
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        test_reset_r1();
        test_period_r2();
        test_disabled_r3();
        test_reload_r4();
        test_high_r5();
        test_idle_r6();
        test_start_r7();
        test_sticky_r9();
        test_zero_r10();
        finish_up();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

endmodule